// File: doc/BRIEF.md
# Duplicate Packet Parity Table

This block keeps one alternating transaction bit for every node on a 64-node network. Both directions of a link use it to tell a fresh packet from a retransmission of one that was already taken. On the sending side, the block returns the parity bit that goes into an outgoing packet for a chosen destination. When the destination acknowledges the packet, the block flips that destination's bit. A NAK or a timeout leaves the bit alone.

On the receiving side, the block takes the header fields of a packet that has already passed its CRC check: the source node, the retry count, the parity bit, a synchronization flag and a "will be NAKed" flag. One cycle later it gives a registered verdict, and in the same clock edge it updates the source's entry. Packet parsing, the CRC check and ACK generation all stay in the neighbouring logic. That logic reads the verdict to decide whether to ACK, re-ACK, NAK or stay silent.

The table lives inside the block. It can only be seen through `tx_parity_o`, which always reads as the complement of the selected entry.

Top module: `dup_parity_table`

## Requirements
- R1: After reset every entry is 0, so `tx_parity_o` reads 1 for every node.
- R2: `tx_parity_o` is combinationally the inverse of the entry selected by `tx_node_i`.
- R3: A cycle with `tx_ack_i` high flips the entry of `tx_ack_node_i` at the next clock edge. If there is no ACK, the entry keeps its value.
- R4: A non-sync packet with retry count zero is never classed as a duplicate.
- R5: A non-sync packet with a nonzero retry count and a parity equal to the source entry gives code 2'b01 (re-ACK and discard). The entry is not changed.
- R6: An accepted packet gives code 2'b00, and its parity bit is copied into the source entry.
- R7: A packet flagged with `rx_nak_i` that is neither sync nor a duplicate gives code 2'b11. The entry is not changed.
- R8: A sync packet gives code 2'b10 (no ACK) and clears the source entry to 0, whatever its retry count and parity are.
- R9: The verdict is registered. `dec_valid_o`, `dec_code_o` and `dec_src_o` appear one clock after the packet is presented, and `dec_valid_o` is high for exactly one cycle per packet. Back-to-back packets from the same source are each judged on the table as updated by the one before.
- R10: A receive update and an ACK flip in the same cycle both take effect when they address different entries. When both address the same entry, the receive update wins and the flip is dropped.
- R11: Classification priority is sync, then duplicate, then NAK, then accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_node_i | input | NODE_W | Destination whose parity is looked up |
| tx_parity_o | output | 1 | Parity bit to place in the packet for `tx_node_i` |
| tx_ack_i | input | 1 | ACK received for a transmission |
| tx_ack_node_i | input | NODE_W | Node that sent the ACK |
| rx_valid_i | input | 1 | Good packet header present |
| rx_src_i | input | NODE_W | Source node of the packet |
| rx_retry_i | input | RETRY_W | Retry count from the header |
| rx_parity_i | input | 1 | Parity bit from the header |
| rx_sync_i | input | 1 | Packet is a synchronization packet |
| rx_nak_i | input | 1 | Packet will be NAKed (size mismatch) |
| dec_valid_o | output | 1 | Verdict valid, one-cycle pulse |
| dec_code_o | output | 2 | 00 accept+ACK, 01 re-ACK+discard, 10 sync no ACK, 11 NAK hold |
| dec_src_o | output | NODE_W | Source node the verdict refers to |

## Verification
The receive path is tested with these patterns:
- First attempts with each parity value, which separate retry-zero acceptance from duplicate detection.
- Retries whose parity matches the stored bit, and retries whose parity does not match, which separate a genuine retransmission from a new transaction.
- Sync packets carrying duplicate-like fields, and NAK-flagged duplicates, which pin down the priority order.

The transmit path is tested with these patterns:
- Repeated ACKs, which show the flip.
- Idle stretches, which show that nothing changes without an ACK.

Collision patterns drive a receive update and an ACK flip in the same cycle, once to different entries and once to the same entry. A sweep over all 64 nodes checks the first and last entries and shows that no entry aliases another.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  typedef enum logic [1:0] {
    DEC_ACCEPT = 2'b00,
    DEC_DUP    = 2'b01,
    DEC_SYNC   = 2'b10,
    DEC_NAK    = 2'b11
  } rx_dec_e;
endpackage

// File: rtl/dpt_table.sv
module dpt_table #(
  parameter int NODE_W = 6,
  localparam int NODES = 1 << NODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_we_i,
  input  logic [NODE_W-1:0] rx_idx_i,
  input  logic              rx_val_i,
  input  logic              tgl_i,
  input  logic [NODE_W-1:0] tgl_idx_i,
  input  logic [NODE_W-1:0] rd_a_idx_i,
  output logic              rd_a_o,
  input  logic [NODE_W-1:0] rd_b_idx_i,
  output logic              rd_b_o
);
  logic [NODES-1:0] bits_q;

  for (genvar g = 0; g < NODES; g++) begin : g_ent
    logic hit_rx, hit_tgl;
    assign hit_rx  = rx_we_i && (rx_idx_i == NODE_W'(g));
    assign hit_tgl = tgl_i && (tgl_idx_i == NODE_W'(g));
    // receive write has priority over ACK flip
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      bits_q[g] <= 1'b0;
      else if (hit_rx)  bits_q[g] <= rx_val_i;
      else if (hit_tgl) bits_q[g] <= ~bits_q[g];
    end
  end

  assign rd_a_o = bits_q[rd_a_idx_i];
  assign rd_b_o = bits_q[rd_b_idx_i];
endmodule

// File: rtl/dpt_tx_port.sv
module dpt_tx_port #(
  parameter int NODE_W = 6
) (
  input  logic [NODE_W-1:0] node_i,
  input  logic              entry_i,
  output logic [NODE_W-1:0] rd_idx_o,
  output logic              parity_o,
  input  logic              ack_i,
  input  logic [NODE_W-1:0] ack_node_i,
  output logic              tgl_o,
  output logic [NODE_W-1:0] tgl_idx_o
);
  assign rd_idx_o  = node_i;
  assign parity_o  = ~entry_i;
  assign tgl_o     = ack_i;
  assign tgl_idx_o = ack_node_i;
endmodule

// File: rtl/dpt_rx_classify.sv
module dpt_rx_classify
  import dpt_pkg::*;
#(
  parameter int NODE_W  = 6,
  parameter int RETRY_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [NODE_W-1:0]  src_i,
  input  logic [RETRY_W-1:0] retry_i,
  input  logic               parity_i,
  input  logic               sync_i,
  input  logic               nak_i,
  input  logic               entry_i,
  output logic               we_o,
  output logic               wval_o,
  output logic               dec_valid_o,
  output rx_dec_e            dec_o,
  output logic [NODE_W-1:0]  dec_src_o
);
  rx_dec_e dec_d;
  logic    is_dup;

  assign is_dup = (retry_i != '0) && (parity_i == entry_i);

  always_comb begin
    if (sync_i)      dec_d = DEC_SYNC;
    else if (is_dup) dec_d = DEC_DUP;
    else if (nak_i)  dec_d = DEC_NAK;
    else             dec_d = DEC_ACCEPT;
  end

  always_comb begin
    we_o   = 1'b0;
    wval_o = 1'b0;
    if (valid_i) begin
      unique case (dec_d)
        DEC_SYNC:   begin we_o = 1'b1; wval_o = 1'b0;     end
        DEC_ACCEPT: begin we_o = 1'b1; wval_o = parity_i; end
        default:    begin we_o = 1'b0; wval_o = 1'b0;     end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      dec_o       <= DEC_ACCEPT;
      dec_src_o   <= '0;
    end else begin
      dec_valid_o <= valid_i;
      if (valid_i) begin
        dec_o     <= dec_d;
        dec_src_o <= src_i;
      end
    end
  end
endmodule

// File: rtl/dup_parity_table.sv
module dup_parity_table
  import dpt_pkg::*;
#(
  parameter int NODE_W  = 6,
  parameter int RETRY_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NODE_W-1:0]  tx_node_i,
  output logic               tx_parity_o,
  input  logic               tx_ack_i,
  input  logic [NODE_W-1:0]  tx_ack_node_i,
  input  logic               rx_valid_i,
  input  logic [NODE_W-1:0]  rx_src_i,
  input  logic [RETRY_W-1:0] rx_retry_i,
  input  logic               rx_parity_i,
  input  logic               rx_sync_i,
  input  logic               rx_nak_i,
  output logic               dec_valid_o,
  output logic [1:0]         dec_code_o,
  output logic [NODE_W-1:0]  dec_src_o
);
  logic [NODE_W-1:0] tx_rd_idx, tgl_idx;
  logic              tx_entry, rx_entry, tgl, rx_we, rx_wval;
  rx_dec_e           dec;

  dpt_tx_port #(.NODE_W(NODE_W)) u_tx (
    .node_i     (tx_node_i),
    .entry_i    (tx_entry),
    .rd_idx_o   (tx_rd_idx),
    .parity_o   (tx_parity_o),
    .ack_i      (tx_ack_i),
    .ack_node_i (tx_ack_node_i),
    .tgl_o      (tgl),
    .tgl_idx_o  (tgl_idx)
  );

  dpt_rx_classify #(.NODE_W(NODE_W), .RETRY_W(RETRY_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (rx_valid_i),
    .src_i       (rx_src_i),
    .retry_i     (rx_retry_i),
    .parity_i    (rx_parity_i),
    .sync_i      (rx_sync_i),
    .nak_i       (rx_nak_i),
    .entry_i     (rx_entry),
    .we_o        (rx_we),
    .wval_o      (rx_wval),
    .dec_valid_o (dec_valid_o),
    .dec_o       (dec),
    .dec_src_o   (dec_src_o)
  );

  dpt_table #(.NODE_W(NODE_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_we_i    (rx_we),
    .rx_idx_i   (rx_src_i),
    .rx_val_i   (rx_wval),
    .tgl_i      (tgl),
    .tgl_idx_i  (tgl_idx),
    .rd_a_idx_i (tx_rd_idx),
    .rd_a_o     (tx_entry),
    .rd_b_idx_i (rx_src_i),
    .rd_b_o     (rx_entry)
  );

  assign dec_code_o = dec;
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
  parameter int NODE_W  = 6,
  parameter int RETRY_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NODE_W-1:0]  tx_node_i,
  input logic               tx_parity_o,
  input logic               tx_ack_i,
  input logic [NODE_W-1:0]  tx_ack_node_i,
  input logic               rx_valid_i,
  input logic [NODE_W-1:0]  rx_src_i,
  input logic [RETRY_W-1:0] rx_retry_i,
  input logic               rx_sync_i,
  input logic               rx_nak_i,
  input logic               dec_valid_o,
  input logic [1:0]         dec_code_o,
  input logic [NODE_W-1:0]  dec_src_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_dec_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    dec_valid_o |-> $past(rx_valid_i));

  assert_src_echo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    dec_valid_o |-> dec_src_o == $past(rx_src_i));

  assert_sync_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (rx_valid_i && rx_sync_i) |=> dec_code_o == 2'b10);

  assert_first_try_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (rx_valid_i && !rx_sync_i && !rx_nak_i && rx_retry_i == '0) |=> dec_code_o == 2'b00);

  assert_dup_retry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (dec_valid_o && dec_code_o == 2'b01) |-> $past(rx_retry_i) != '0);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(!tx_ack_i && !rx_valid_i) && $stable(tx_node_i)) |-> $stable(tx_parity_o));

  assert_flip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(tx_ack_i && !rx_valid_i && tx_ack_node_i == tx_node_i) && $stable(tx_node_i))
      |-> tx_parity_o != $past(tx_parity_o));
endmodule

bind dup_parity_table dpt_checker #(.NODE_W(NODE_W), .RETRY_W(RETRY_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_node_i     (tx_node_i),
  .tx_parity_o   (tx_parity_o),
  .tx_ack_i      (tx_ack_i),
  .tx_ack_node_i (tx_ack_node_i),
  .rx_valid_i    (rx_valid_i),
  .rx_src_i      (rx_src_i),
  .rx_retry_i    (rx_retry_i),
  .rx_sync_i     (rx_sync_i),
  .rx_nak_i      (rx_nak_i),
  .dec_valid_o   (dec_valid_o),
  .dec_code_o    (dec_code_o),
  .dec_src_o     (dec_src_o)
);

// File: tb/dup_parity_table_test.sv
module dup_parity_table_test;
  localparam int NODE_W  = 6;
  localparam int RETRY_W = 4;
  localparam int NODES   = 1 << NODE_W;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NODE_W-1:0]  tx_node_i = '0;
  logic               tx_parity_o;
  logic               tx_ack_i = 1'b0;
  logic [NODE_W-1:0]  tx_ack_node_i = '0;
  logic               rx_valid_i = 1'b0;
  logic [NODE_W-1:0]  rx_src_i = '0;
  logic [RETRY_W-1:0] rx_retry_i = '0;
  logic               rx_parity_i = 1'b0;
  logic               rx_sync_i = 1'b0;
  logic               rx_nak_i = 1'b0;
  logic               dec_valid_o;
  logic [1:0]         dec_code_o;
  logic [NODE_W-1:0]  dec_src_o;

  always #4 clk = ~clk;

  dup_parity_table #(.NODE_W(NODE_W), .RETRY_W(RETRY_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_node_i(tx_node_i), .tx_parity_o(tx_parity_o),
    .tx_ack_i(tx_ack_i), .tx_ack_node_i(tx_ack_node_i),
    .rx_valid_i(rx_valid_i), .rx_src_i(rx_src_i), .rx_retry_i(rx_retry_i),
    .rx_parity_i(rx_parity_i), .rx_sync_i(rx_sync_i), .rx_nak_i(rx_nak_i),
    .dec_valid_o(dec_valid_o), .dec_code_o(dec_code_o), .dec_src_o(dec_src_o)
  );

  int checks = 0;
  int fails  = 0;
  logic mdl [NODES];
  logic [NODE_W+1:0] expq [$];
  string tagq [$];

  // requirement model of one receive verdict
  function automatic logic [1:0] expect_code(logic [NODE_W-1:0] s, logic [RETRY_W-1:0] r,
                                             logic p, logic sy, logic nk);
    if (sy) return 2'b10;
    if (r != '0 && p == mdl[s]) return 2'b01;
    if (nk) return 2'b11;
    return 2'b00;
  endfunction

  task automatic step(input logic rv, input logic [NODE_W-1:0] s, input logic [RETRY_W-1:0] r,
                      input logic p, input logic sy, input logic nk,
                      input logic av, input logic [NODE_W-1:0] an, input string tag);
    logic [1:0] c;
    logic rx_wr;
    @(negedge clk);
    rx_valid_i = rv; rx_src_i = s; rx_retry_i = r; rx_parity_i = p;
    rx_sync_i = sy; rx_nak_i = nk; tx_ack_i = av; tx_ack_node_i = an;
    rx_wr = 1'b0;
    if (rv) begin
      c = expect_code(s, r, p, sy, nk);
      expq.push_back({c, s});
      tagq.push_back(tag);
      if (c == 2'b10) begin mdl[s] = 1'b0; rx_wr = 1'b1; end
      if (c == 2'b00) begin mdl[s] = p;    rx_wr = 1'b1; end
    end
    if (av && !(rx_wr && an == s)) mdl[an] = ~mdl[an];
  endtask

  task automatic idle();
    @(negedge clk);
    rx_valid_i = 1'b0; tx_ack_i = 1'b0; rx_sync_i = 1'b0; rx_nak_i = 1'b0;
  endtask

  task automatic rx(input logic [NODE_W-1:0] s, input logic [RETRY_W-1:0] r, input logic p,
                    input logic sy, input logic nk, input string tag);
    step(1'b1, s, r, p, sy, nk, 1'b0, '0, tag);
    idle();
  endtask

  task automatic ack(input logic [NODE_W-1:0] n);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, n, "R3");
    idle();
  endtask

  task automatic check_par(input logic [NODE_W-1:0] n, input string tag);
    @(negedge clk);
    tx_node_i = n;
    #1;
    checks++;
    if (tx_parity_o !== ~mdl[n]) begin
      fails++;
      $display("FAIL %s: node %0d tx_parity actual %b expected %b", tag, n, tx_parity_o, ~mdl[n]);
    end
  endtask

  // monitor: pops expected verdicts as they appear
  always @(negedge clk) begin
    if (rst_ni && dec_valid_o) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R9: unexpected verdict code %b src %0d expected none", dec_code_o, dec_src_o);
      end else begin
        logic [NODE_W+1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if ({dec_code_o, dec_src_o} !== e) begin
          fails++;
          $display("FAIL %s: verdict actual code %b src %0d expected code %b src %0d",
                   t, dec_code_o, dec_src_o, e[NODE_W+1:NODE_W], e[NODE_W-1:0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NODES; i++) mdl[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    check_par(0, "R1"); check_par(63, "R1"); check_par(17, "R1");
    // R2 R3 ACK flips, no ACK holds
    ack(5); check_par(5, "R2");
    ack(5); check_par(5, "R3");
    repeat (4) idle();
    check_par(5, "R3");
    // R4 R6 first attempt accepted, parity copied
    rx(9, 0, 1'b1, 1'b0, 1'b0, "R4"); check_par(9, "R6");
    // R5 retry with equal parity -> duplicate, entry held
    rx(9, 2, 1'b1, 1'b0, 1'b0, "R5"); check_par(9, "R5");
    // R6 retry with different parity -> new transaction
    rx(9, 2, 1'b0, 1'b0, 1'b0, "R6"); check_par(9, "R6");
    // R4 retry zero with equal parity still accepted
    rx(9, 0, 1'b0, 1'b0, 1'b0, "R4"); check_par(9, "R4");
    // R7 NAK leaves entry
    rx(12, 0, 1'b1, 1'b0, 1'b1, "R7"); check_par(12, "R7");
    // R8 R11 sync with duplicate-looking fields
    rx(20, 0, 1'b1, 1'b0, 1'b0, "R6"); check_par(20, "R6");
    rx(20, 3, 1'b1, 1'b1, 1'b1, "R8"); check_par(20, "R8");
    // R11 duplicate beats NAK
    rx(9, 1, 1'b0, 1'b0, 1'b1, "R11"); check_par(9, "R11");
    // R9 back-to-back same source
    step(1'b1, 33, 0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R9");
    step(1'b1, 33, 1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R9");
    step(1'b1, 33, 1, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9");
    idle(); check_par(33, "R9");
    // R10 collisions
    step(1'b1, 30, 0, 1'b1, 1'b0, 1'b0, 1'b1, 31, "R10");
    idle(); check_par(30, "R10"); check_par(31, "R10");
    step(1'b1, 40, 0, 1'b0, 1'b0, 1'b0, 1'b1, 40, "R10");
    idle(); check_par(40, "R10");
    step(1'b1, 41, 0, 1'b0, 1'b0, 1'b1, 1'b1, 41, "R10");
    idle(); check_par(41, "R10");
    // full sweep of all entries
    for (int n = 0; n < NODES; n++)
      step(1'b1, NODE_W'(n), 0, n[0] ^ n[3], 1'b0, 1'b0, 1'b0, '0, "R6");
    idle();
    for (int n = 0; n < NODES; n++) check_par(NODE_W'(n), "R6");
    repeat (3) idle();
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R9: %0d verdicts missing expected 0", expq.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule